// File: doc/BRIEF.md
# Pause Detector Timing Qualifier

This block turns a stream of digitised audio magnitudes into a clean, debounced pause indication for the front end of a broadcast data receiver. On every clock the level sample is compared against one of four fixed thresholds, which are spaced about 4 dB apart. A pause is declared only when the level stays below the threshold for a programmable minimum time. Eight entry times are available, from 3 ms to 100 ms. Once a pause is active, it ends only after the level stays at or above the threshold for a fixed 5 ms. A short burst of audio therefore cannot break a pause.

The pause flag is active low. A single-cycle start event marks the clock on which a new pause begins, so that a controller can launch an alternative-frequency search from it. All times are counted in system clock cycles. The clock rate is a parameter, with a default of 4.332 MHz. Rectification and filtering of the audio happen upstream of this block.

Top module: `pause_qual`

## Requirements
- R1: While reset is asserted and on the first clock after reset, `pause_n_o` is 1 and `pause_start_o` is 0. Reset clears any qualification in progress, so a full entry time is needed after it.
- R2: `thr_sel_i` selects the threshold: 0 gives 0x100, 1 gives 0x0A2, 2 gives 0x066 and 3 gives 0x040. A sample counts as below only when `level_i` is strictly less than the selected threshold. A sample equal to the threshold counts as above.
- R3: With no pause active, `pause_n_o` falls on the clock edge that samples the N-th consecutive below sample. N = ms × CLK_HZ / 1000, where ms comes from `time_sel_i` codes 0..7: 3, 6, 12, 20, 35, 50, 75 and 100 ms.
- R4: With a pause active, `pause_n_o` rises on the clock edge that samples the M-th consecutive sample that is not below the threshold, with M = 5 × CLK_HZ / 1000.
- R5: `pause_start_o` is high for exactly the one cycle in which `pause_n_o` has just fallen, and it is never high at the end of a pause.
- R6: During a pause, a single below sample restarts the exit count.
- R7: Before a pause, a single sample that is not below the threshold restarts the entry count.
- R8: A clock on which `thr_sel_i` or `time_sel_i` differs from its value on the previous clock restarts the current qualification, and that sample is not counted. No output changes on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| level_i | input | LVL_W | Digitised audio magnitude, one sample per clock |
| thr_sel_i | input | 2 | Threshold select code |
| time_sel_i | input | 3 | Pause entry time code |
| pause_n_o | output | 1 | Qualified pause flag, low while a pause is active |
| pause_start_o | output | 1 | One-cycle event on the start of a pause |

## Verification
Two functions can fall on the same clock. A configuration change can arrive on the very edge that would complete an entry or exit count. A below sample can arrive on the last cycle of the exit interval. The bench provokes the first case by changing the timing code on the 30th consecutive below sample under a 30-cycle entry setting. It provokes the second by changing the threshold code on the final cycle of an exit. In both cases the edge must leave the output unchanged and start a full new count. A behavioural reference model of the counts is compared against both outputs on every clock, and hand-computed checks confirm the outcome at the exact boundary cycles.

// File: rtl/pause_qual_pkg.sv
package pause_qual_pkg;

  localparam int THR_W        = 9;
  localparam int NUM_TCODE    = 8;
  localparam int EXIT_MS      = 5;
  localparam int MAX_ENTRY_MS = 100;

  typedef enum logic {
    PH_SEEK = 1'b0,
    PH_HOLD = 1'b1
  } phase_e;

  // Threshold magnitude for a select code, steps about 4 dB apart
  function automatic logic [THR_W-1:0] thr_level(input logic [1:0] sel);
    logic [THR_W-1:0] v;
    case (sel)
      2'd0:    v = 9'h100;
      2'd1:    v = 9'h0A2;
      2'd2:    v = 9'h066;
      default: v = 9'h040;
    endcase
    return v;
  endfunction

  // Entry time in milliseconds for a timing code
  function automatic int unsigned entry_ms(input logic [2:0] code);
    int unsigned v;
    case (code)
      3'd0:    v = 3;
      3'd1:    v = 6;
      3'd2:    v = 12;
      3'd3:    v = 20;
      3'd4:    v = 35;
      3'd5:    v = 50;
      3'd6:    v = 75;
      default: v = 100;
    endcase
    return v;
  endfunction

  function automatic int unsigned ms_to_cycles(input int unsigned ms,
                                               input int unsigned cyc_per_ms);
    return ms * cyc_per_ms;
  endfunction

endpackage

// File: rtl/pause_qual_cmp.sv
module pause_qual_cmp
  import pause_qual_pkg::*;
#(
  parameter int LVL_W = 10
) (
  input  logic [LVL_W-1:0] level,
  input  logic [1:0]       sel,
  output logic             below
);

  logic [LVL_W-1:0] thr_ext;

  assign thr_ext = LVL_W'(thr_level(sel));
  assign below   = (level < thr_ext);

endmodule

// File: rtl/pause_qual_cfgwatch.sv
module pause_qual_cfgwatch #(
  parameter int CFG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg,
  output logic             chg
);

  logic [CFG_W-1:0] prev_q;
  logic             primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= cfg;
      primed_q <= 1'b1;
    end
  end

  assign chg = primed_q && (cfg != prev_q);

endmodule

// File: rtl/pause_qual_timer.sv
module pause_qual_timer #(
  parameter int CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic [CNT_W-1:0] lim,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);

  logic [CNT_W:0] nxt;

  assign nxt = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign hit = inc && (nxt >= {1'b0, lim});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!inc || hit)  cnt <= '0;
    else                   cnt <= nxt[CNT_W-1:0];
  end

endmodule

// File: rtl/pause_qual.sv
module pause_qual
  import pause_qual_pkg::*;
#(
  parameter int CLK_HZ = 4332000,
  parameter int LVL_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level_i,
  input  logic [1:0]       thr_sel_i,
  input  logic [2:0]       time_sel_i,
  output logic             pause_n_o,
  output logic             pause_start_o
);

  localparam int CYC_PER_MS = CLK_HZ / 1000;
  localparam int MAX_CYC    = MAX_ENTRY_MS * CYC_PER_MS;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);
  localparam int CFG_W      = 5;

  // Named internal events, observed by the bound checker
  logic             below_w;
  logic             cfg_chg_w;
  logic             hit_w;
  logic             inc_w;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] lim_w;

  phase_e           phase_q;
  logic             start_q;

  logic [CNT_W-1:0] entry_tab [NUM_TCODE];
  logic [CNT_W-1:0] exit_lim;

  for (genvar g = 0; g < NUM_TCODE; g++) begin : g_entry
    assign entry_tab[g] = CNT_W'(ms_to_cycles(entry_ms(3'(g)), CYC_PER_MS));
  end

  assign exit_lim = CNT_W'(ms_to_cycles(EXIT_MS, CYC_PER_MS));

  pause_qual_cmp #(.LVL_W(LVL_W)) u_cmp (
    .level (level_i),
    .sel   (thr_sel_i),
    .below (below_w)
  );

  pause_qual_cfgwatch #(.CFG_W(CFG_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .cfg   ({time_sel_i, thr_sel_i}),
    .chg   (cfg_chg_w)
  );

  assign lim_w = (phase_q == PH_HOLD) ? exit_lim : entry_tab[time_sel_i];
  assign inc_w = !cfg_chg_w && ((phase_q == PH_HOLD) ? !below_w : below_w);

  pause_qual_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (inc_w),
    .lim   (lim_w),
    .cnt   (cnt_w),
    .hit   (hit_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SEEK;
      start_q <= 1'b0;
    end else begin
      start_q <= hit_w && (phase_q == PH_SEEK);
      if (hit_w)
        phase_q <= (phase_q == PH_SEEK) ? PH_HOLD : PH_SEEK;
    end
  end

  assign pause_n_o     = (phase_q != PH_HOLD);
  assign pause_start_o = start_q;

endmodule

// File: rtl/pause_qual_chk.sv
module pause_qual_chk #(
  parameter int CNT_W = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pause_n,
  input logic             pause_start,
  input logic             below,
  input logic             cfg_chg,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] lim
);

  // R5
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pause_start |-> !pause_n);

  // R5
  fall_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pause_n) |-> pause_start);

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> $stable(pause_n));

  // R6
  rise_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pause_n) |-> !$past(below));

  // R7
  fall_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pause_n) |-> $past(below));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_chg |-> (cnt < lim));

endmodule

bind pause_qual pause_qual_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pause_n     (pause_n_o),
  .pause_start (pause_start_o),
  .below       (below_w),
  .cfg_chg     (cfg_chg_w),
  .cnt         (cnt_w),
  .lim         (lim_w)
);

// File: tb/pause_qual_test.sv
`timescale 1ns/1ps
module pause_qual_test;

  localparam int TB_HZ = 10000;
  localparam int CPMS  = TB_HZ / 1000;
  localparam int LW    = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [LW-1:0] level_i = 10'h1FF;
  logic [1:0]    thr_sel_i = 2'd0;
  logic [2:0]    time_sel_i = 3'd0;
  logic          pause_n_o;
  logic          pause_start_o;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  pause_qual #(.CLK_HZ(TB_HZ), .LVL_W(LW)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .level_i       (level_i),
    .thr_sel_i     (thr_sel_i),
    .time_sel_i    (time_sel_i),
    .pause_n_o     (pause_n_o),
    .pause_start_o (pause_start_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int ms_tab[8] = '{3, 6, 12, 20, 35, 50, 75, 100};
  int thr_tab[4] = '{256, 162, 102, 64};

  bit m_pause = 0;
  bit m_start = 0;
  bit m_primed = 0;
  int m_run = 0;
  int m_prev = 0;

  always @(posedge clk) begin
    int cfg;
    bit chg;
    bit blw;
    if (!rst_n) begin
      m_pause = 0; m_start = 0; m_primed = 0; m_run = 0; m_prev = 0;
    end else begin
      cfg = int'(time_sel_i) * 4 + int'(thr_sel_i);
      chg = m_primed && (cfg != m_prev);
      m_prev = cfg;
      m_primed = 1;
      blw = int'(level_i) < thr_tab[thr_sel_i];
      m_start = 0;
      if (!m_pause) begin
        if (blw && !chg) begin
          m_run++;
          if (m_run >= ms_tab[time_sel_i] * CPMS) begin
            m_pause = 1; m_run = 0; m_start = 1;
          end
        end else m_run = 0;
      end else begin
        if (!blw && !chg) begin
          m_run++;
          if (m_run >= 5 * CPMS) begin
            m_pause = 0; m_run = 0;
          end
        end else m_run = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(pause_n_o == !m_pause, "R3 R4 R6 R7 R8 model pause_n", pause_n_o, !m_pause);
      chk(pause_start_o == m_start, "R5 model start", pause_start_o, m_start);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_pn(input bit e, input string tag);
    chk(pause_n_o == e, tag, pause_n_o, e);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #250000;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    cyc(3);
    expect_pn(1, "R1 pause_n in reset");
    chk(pause_start_o == 0, "R1 start in reset", pause_start_o, 0);
    rst_n = 1'b1;
    cyc(2);
    expect_pn(1, "R1 pause_n after reset");
    chk(pause_start_o == 0, "R1 start after reset", pause_start_o, 0);

    // R3 / R5: code 0 -> 30 cycles, threshold 0x100
    level_i = 10'h0FF;
    cyc(29); expect_pn(1, "R3 before entry count");
    cyc(1);  expect_pn(0, "R3 at entry count");
    chk(pause_start_o == 1, "R5 start on entry", pause_start_o, 1);
    cyc(1);  chk(pause_start_o == 0, "R5 start one cycle", pause_start_o, 0);

    // R2 equal counts as above; R6 burst restarts exit
    level_i = 10'h100;
    cyc(48); expect_pn(0, "R4 before exit");
    level_i = 10'h0FF;
    cyc(1);  expect_pn(0, "R6 burst absorbed");
    level_i = 10'h100;
    cyc(49); expect_pn(0, "R6 exit restarted");
    cyc(1);  expect_pn(1, "R4 exit after 50");
    chk(pause_start_o == 0, "R5 no start on exit", pause_start_o, 0);

    // R2 threshold code 3 boundary
    thr_sel_i = 2'd3; level_i = 10'h040;
    cyc(100); expect_pn(1, "R2 equal to 0x40 not below");
    level_i = 10'h03F;
    cyc(30); expect_pn(0, "R2 0x3F below 0x40");
    level_i = 10'h1FF;
    cyc(50); expect_pn(1, "R4 exit");

    // R7 entry restart
    level_i = 10'h03F;
    cyc(29);
    level_i = 10'h040;
    cyc(1); expect_pn(1, "R7 above sample");
    level_i = 10'h03F;
    cyc(29); expect_pn(1, "R7 entry restarted");
    cyc(1);  expect_pn(0, "R7 full entry after restart");
    level_i = 10'h1FF;
    cyc(50); expect_pn(1, "R4 exit");

    // R8 timing code change on the completing cycle
    level_i = 10'h03F;
    cyc(29);
    time_sel_i = 3'd1;
    cyc(1);  expect_pn(1, "R8 change blocks entry");
    cyc(59); expect_pn(1, "R8 new entry count 60");
    cyc(1);  expect_pn(0, "R8 entry after 60");
    // R8 threshold change on the last exit cycle
    level_i = 10'h1FF;
    cyc(49);
    thr_sel_i = 2'd2;
    cyc(1);  expect_pn(0, "R8 change blocks exit");
    cyc(49); expect_pn(0, "R8 exit restarted");
    cyc(1);  expect_pn(1, "R8 exit after 50");

    // R3 longest code: 1000 cycles
    level_i = 10'h03F; time_sel_i = 3'd7;
    cyc(1000); expect_pn(1, "R3 code 7 before 1000");
    cyc(1);    expect_pn(0, "R3 code 7 at 1000");
    level_i = 10'h1FF;
    cyc(50); expect_pn(1, "R4 exit");

    // R2 code 1 (0xA2), timing code 2 (120 cycles)
    thr_sel_i = 2'd1; time_sel_i = 3'd2; level_i = 10'h0A2;
    cyc(200); expect_pn(1, "R2 equal to 0xA2 not below");
    level_i = 10'h0A1;
    cyc(119); expect_pn(1, "R3 code 2 before 120");
    cyc(1);   expect_pn(0, "R3 code 2 at 120");

    // R1 reset during pause clears all
    rst_n = 1'b0;
    #0.1;
    expect_pn(1, "R1 reset releases pause");
    cyc(1);
    rst_n = 1'b1;
    cyc(119); expect_pn(1, "R1 count cleared by reset");
    cyc(1);   expect_pn(0, "R1 full entry after reset");
    cyc(2);

    finish_run();
  end

endmodule